// File: doc/BRIEF.md
# Binary to Quinary Symbol Mapper and De-Mapper

This block turns 16-bit parallel words into groups of seven base-5 symbols for a three-wire serial link whose clock is carried in the data. It also turns such groups back into words. Five symbol values are available per slot, and 5^7 = 78125 is the smallest power of five that reaches 2^16 = 65536. Seven symbols therefore carry one word, at 16/7 ≈ 2.28 bits per symbol. That rate sits just below the ceiling of log2(5) ≈ 2.32 bits for a five-valued symbol.

On the transmit side, a word arrives through a valid/ready handshake. It is then issued as seven 3-bit symbol codes through a second valid/ready handshake, most significant base-5 digit first, towards the wire-state encoder. A new word is taken only once all seven codes of the current word have been handed over.

On the receive side, the block collects seven codes, also most significant first, and rebuilds the word. It flags the word when the seven digits add up to 65536 or more, or when any code lies outside 0..4. Both sides share one clock and one synchronous active-high reset.

Top module: `quinary_codec`

## Requirements
- R1: `in_ready` is high when the mapper is idle, and a word is taken on a cycle with `in_valid` and `in_ready` both high. From that cycle until the seventh symbol handshake, `in_ready` is low and `in_valid`/`in_word` have no effect.
- R2: Each accepted word yields exactly seven symbols. `sym_valid` stays high until the seventh handshake, and the symbol advances only on a cycle with `sym_valid` and `sym_ready` both high. While `sym_ready` is low, `sym_code` holds its value.
- R3: The k-th symbol of word w (k = 0..6) carries the code floor(w / 5^(6-k)) mod 5 as a plain 3-bit binary number in 0..4, so the most significant digit goes first.
- R4: In the cycle after the seventh symbol handshake, `sym_valid` is low and `in_ready` is high.
- R5: The de-mapper takes one code on each cycle with `rx_valid` high, the first code being the most significant digit. Cycles with `rx_valid` low change nothing.
- R6: In the cycle after the seventh received code, `out_valid` is high for exactly one cycle and `out_word` holds the low 16 bits of the accumulated value.
- R7: `out_err` is high with the word when the accumulated seven-digit value is 65536 or more; `out_word` still carries its low 16 bits.
- R8: Codes 5, 6 and 7 are illegal. Each one counts as digit 0 and sets `out_err` for the word it belongs to.
- R9: Reset (`rst` high at a clock edge) leaves the mapper idle, with `sym_valid` low and `in_ready` high. It also discards any partially received group and leaves `out_valid` low.
- R10: A word passed through the mapper and then through the de-mapper comes back unchanged, with `out_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word offered to the mapper |
| in_ready | output | 1 | Mapper can take a word |
| in_word | input | 16 | Word to map |
| sym_valid | output | 1 | Symbol code available |
| sym_ready | input | 1 | Encoder takes the symbol |
| sym_code | output | 3 | Base-5 digit, 0..4 |
| rx_valid | input | 1 | Received code present |
| rx_code | input | 3 | Received base-5 digit |
| out_valid | output | 1 | Rebuilt word present (one cycle) |
| out_word | output | 16 | Rebuilt word |
| out_err | output | 1 | Value out of range or illegal code in the group |

## Verification
A corrupted remainder or position register in the mapper shows up on `sym_code` at the very next handshake. It also breaks the round trip once the group ends, eight or fewer cycles later. A de-mapper counter that drifts out of step moves the `out_valid` pulse away from the seventh code. A bad accumulator or a stale error flag gives the wrong `out_word` or `out_err` one cycle after the group closes. The sweep drives enough words, stall patterns, illegal codes and out-of-range groups that such faults meet a check within one word.

// File: rtl/quinary_codec.sv
module quinary_codec #(
  parameter int WORD_W = 16,
  parameter int RADIX  = 5,
  parameter int NSYM   = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [WORD_W-1:0]           in_word,
  output logic                        sym_valid,
  input  logic                        sym_ready,
  output logic [$clog2(RADIX)-1:0]    sym_code,
  input  logic                        rx_valid,
  input  logic [$clog2(RADIX)-1:0]    rx_code,
  output logic                        out_valid,
  output logic [WORD_W-1:0]           out_word,
  output logic                        out_err
);

  localparam int SYM_W = $clog2(RADIX);
  localparam int ACC_W = $clog2(RADIX ** NSYM);
  localparam int POS_W = $clog2(NSYM);
  localparam logic [ACC_W-1:0] WORD_LIM = ACC_W'(2 ** WORD_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NSYM - 1);

  function automatic logic [ACC_W-1:0] place_of(input logic [POS_W-1:0] p);
    logic [ACC_W-1:0] r;
    r = ACC_W'(1);
    for (int i = 0; i < NSYM; i++)
      if (i < int'(p)) r = r * ACC_W'(RADIX);
    return r;
  endfunction

  // transmit side
  logic             busy;
  logic [POS_W-1:0] pos;
  logic [ACC_W-1:0] rem;
  logic [ACC_W-1:0] place;
  logic [ACC_W-1:0] step;
  logic [SYM_W-1:0] digit;

  always_comb begin
    place = place_of(pos);
    digit = '0;
    step  = '0;
    for (int d = 1; d < RADIX; d++)
      if (rem >= place * ACC_W'(d)) begin
        digit = SYM_W'(d);
        step  = place * ACC_W'(d);
      end
  end

  assign in_ready  = !busy;
  assign sym_valid = busy;
  assign sym_code  = digit;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      pos  <= '0;
      rem  <= '0;
    end else if (in_valid && !busy) begin
      busy <= 1'b1;
      pos  <= LAST_POS;
      rem  <= ACC_W'(in_word);
    end else if (busy && sym_ready) begin
      rem <= rem - step;
      if (pos == '0) busy <= 1'b0;
      else           pos  <= pos - 1'b1;
    end
  end

  // receive side
  logic [POS_W-1:0] cnt;
  logic [ACC_W-1:0] acc;
  logic             bad;
  logic             illegal;
  logic [ACC_W-1:0] acc_nxt;

  assign illegal = int'(rx_code) >= RADIX;
  assign acc_nxt = acc * ACC_W'(RADIX) + (illegal ? '0 : ACC_W'(rx_code));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      acc       <= '0;
      bad       <= 1'b0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (rx_valid) begin
        if (cnt == LAST_POS) begin
          out_valid <= 1'b1;
          out_word  <= acc_nxt[WORD_W-1:0];
          out_err   <= bad || illegal || (acc_nxt >= WORD_LIM);
          cnt       <= '0;
          acc       <= '0;
          bad       <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
          acc <= acc_nxt;
          bad <= bad || illegal;
        end
      end
    end
  end

endmodule

// File: rtl/quinary_codec_chk.sv
module quinary_codec_chk #(
  parameter int WORD_W = 16,
  parameter int SYM_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_word,
  input logic              sym_valid,
  input logic              sym_ready,
  input logic [SYM_W-1:0]  sym_code,
  input logic              rx_valid,
  input logic [SYM_W-1:0]  rx_code,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_word,
  input logic              out_err
);

  logic [2:0] tx_cnt;
  logic [2:0] rx_cnt;
  logic       rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      tx_cnt <= '0;
      rx_cnt <= '0;
    end else begin
      if (sym_valid && sym_ready) tx_cnt <= (tx_cnt == 3'd6) ? 3'd0 : tx_cnt + 3'd1;
      if (rx_valid)               rx_cnt <= (rx_cnt == 3'd6) ? 3'd0 : rx_cnt + 3'd1;
    end
  end

  AST_ACCEPT_ON_GROUP_EDGE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> tx_cnt == 3'd0);                            // R1
  AST_ACCEPT_STARTS_SYMBOLS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> sym_valid && !in_ready);                    // R2
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && !sym_ready) |=> sym_valid && $stable(sym_code));         // R2
  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> sym_code <= 3'd4);                                       // R3
  AST_RELEASE_AFTER_SEVENTH: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_ready && tx_cnt == 3'd6) |=> !sym_valid && in_ready); // R4
  AST_OUT_AFTER_SEVENTH: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(rx_valid) && rx_cnt == 3'd0);                      // R6
  AST_OUT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);                                             // R6
  AST_ILLEGAL_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_code > 3'd4 && rx_cnt == 3'd6) |=> out_valid && out_err); // R8
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> !sym_valid && in_ready && !out_valid);                       // R9

endmodule

bind quinary_codec quinary_codec_chk u_chk (.*);

// File: tb/quinary_codec_test.sv
module quinary_codec_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic        sym_valid;
  logic        sym_ready = 1'b0;
  logic [2:0]  sym_code;
  logic        rx_valid = 1'b0;
  logic [2:0]  rx_code = '0;
  logic        out_valid;
  logic [15:0] out_word;
  logic        out_err;

  int vectors = 0;
  int fails   = 0;
  int stall_ctr = 0;

  always #4 clk = ~clk;

  quinary_codec uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int digit_of(input int v, input int k);
    int pw = 1;
    for (int i = 0; i < 6 - k; i++) pw = pw * 5;
    return (v / pw) % 5;
  endfunction

  task automatic tx_word(input int w, input bit stall, output int cap[7]);
    int k = 0;
    @(negedge clk);
    in_valid = 1'b1; in_word = 16'(w); sym_ready = 1'b0;
    chk(in_ready == 1'b1, "R1 ready when idle", int'(in_ready), 1);
    @(negedge clk);
    in_word = 16'(w) ^ 16'hA5A5;
    while (k < 7) begin
      sym_ready = stall ? ((stall_ctr % 3) != 2) : 1'b1;
      stall_ctr++;
      chk(sym_valid == 1'b1 && in_ready == 1'b0, "R1/R2 busy during group",
          int'({sym_valid, in_ready}), 2);
      if (sym_valid && sym_ready) begin
        cap[k] = int'(sym_code);
        chk(int'(sym_code) == digit_of(w, k), "R3 symbol digit", int'(sym_code), digit_of(w, k));
        k++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0; sym_ready = 1'b0;
    chk(sym_valid == 1'b0 && in_ready == 1'b1, "R4 release after seventh",
        int'({sym_valid, in_ready}), 1);
  endtask

  task automatic rx_group(input int c[7], input bit gap);
    int v = 0;
    bit bad = 1'b0;
    for (int k = 0; k < 7; k++) begin
      v = v * 5 + ((c[k] > 4) ? 0 : c[k]);
      if (c[k] > 4) bad = 1'b1;
    end
    for (int k = 0; k < 7; k++) begin
      if (gap && k > 0) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_code = 3'd7;
      end
      @(negedge clk);
      if (k > 0) chk(out_valid == 1'b0, "R5 no output mid group", int'(out_valid), 0);
      rx_valid = 1'b1; rx_code = 3'(c[k]);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    chk(out_valid == 1'b1, "R6 output after seventh", int'(out_valid), 1);
    chk(int'(out_word) == (v % 65536), "R5/R6/R7 rebuilt word", int'(out_word), v % 65536);
    chk(out_err == (bad || v >= 65536), "R7/R8 error flag", int'(out_err), int'(bad || v >= 65536));
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 single pulse", int'(out_valid), 0);
  endtask

  task automatic value_group(input int v, input bit gap);
    int c[7];
    for (int k = 0; k < 7; k++) c[k] = digit_of(v, k);
    rx_group(c, gap);
  endtask

  task automatic roundtrip(input int w, input bit stall);
    int c[7];
    tx_word(w, stall, c);
    rx_group(c, stall);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int c[7];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(in_ready == 1'b1 && sym_valid == 1'b0 && out_valid == 1'b0, "R9 reset state",
        int'({in_ready, sym_valid, out_valid}), 4);

    // R10 sweep across the word space, alternating encoder stalls
    for (int w = 0; w < 65536; w += 13) roundtrip(w, w[0]);
    roundtrip(65535, 1'b1);
    roundtrip(15624, 1'b0);
    roundtrip(15625, 1'b1);
    roundtrip(3124, 1'b0);

    // R7 out-of-range groups: boundary and sweep above 65535
    value_group(65535, 1'b0);
    value_group(65536, 1'b1);
    value_group(78124, 1'b0);
    for (int v = 65537; v < 78125; v += 97) value_group(v, v[0]);

    // R8 illegal codes at each position
    for (int p = 0; p < 7; p++) begin
      for (int k = 0; k < 7; k++) c[k] = (k + p) % 5;
      c[p] = 5 + (p % 3);
      rx_group(c, p[0]);
    end

    // R9 reset mid group on the de-mapper
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); rx_valid = 1'b1; rx_code = 3'd4;
    end
    @(negedge clk); rx_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    value_group(12345, 1'b0);

    // R9 reset mid word on the mapper
    @(negedge clk); in_valid = 1'b1; in_word = 16'd40000; sym_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk); rst = 1'b1; sym_ready = 1'b0;
    @(negedge clk); rst = 1'b0;
    chk(sym_valid == 1'b0 && in_ready == 1'b1, "R9 mapper idle after reset",
        int'({sym_valid, in_ready}), 1);
    roundtrip(40000, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule